// File: doc/BRIEF.md
# Local-Maximum Search Memory with Valid Tracking

This block is a small two-dimensional store of pixel words with two independent access ports. Each port can write a word, read a word, or issue a search: given the address of a centre pixel, the search returns the largest value in the 3×3 neighbourhood around that pixel and that value's address. The result appears on the port's registered outputs one cycle after the request.

Rows are spread over three banks by row index modulo 3, so any three adjacent rows sit in different banks and all nine neighbourhood words can be fetched together. Inside each bank the three words of a row are compared first. The three row winners are then compared again, and an address generator turns the winning row and column offsets into a word address.

Every word carries a valid bit. A write sets that bit. Reset or a clear pulse drops all of them. A producer fills the memory, and a consumer reads it or searches it. A normal read of an unwritten word, or a search that touches one, reports an invalid result and returns no data.

Top module: `lmx_mem`

## Requirements
- R1: A word's address is row×32 + column, so address bits 8:5 hold the row and bits 4:0 hold the column. A normal read of a written word returns the most recently written value, with o_inv and o_err low and o_addr equal to the request address.
- R2: A read or search issued in cycle t drives o_done high, with its result, for cycle t+1 only. A write, an idle cycle or reset leaves o_done, o_inv, o_err, o_data and o_addr all at zero.
- R3: A normal read of a word whose valid bit is low sets o_inv, with o_data and o_addr zero.
- R4: A search of an interior centre whose nine neighbourhood words are all valid returns the largest of the nine values on o_data and that value's address on o_addr.
- R5: When several neighbourhood words share the largest value, the search returns the earliest of them in raster order: top row first, then left to right within a row.
- R6: Search comparisons treat pixel words as unsigned numbers, so 0x80000000 beats 0x7FFFFFFF.
- R7: A search of an interior centre where any of the nine neighbourhood words is invalid sets o_inv, with o_data and o_addr zero.
- R8: A search whose centre is in row 0, row ROWS-1, column 0 or column COLS-1 sets o_err, as does any read or search with a row of ROWS or more. o_err wins over o_inv, and o_inv, o_data and o_addr are then zero.
- R9: Reset clears every valid bit, and so does i_clr high in a cycle. A write in the same cycle as i_clr leaves its word valid.
- R10: The two ports work at the same time on different words. When both ports write the same word in one cycle, port 0's data is kept.
- R11: A read or search sees the memory as it stood before the writes of the same cycle, on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_clr | input | 1 | Clears all valid bits at this edge |
| i_en | input | 2 | Per-port request enable |
| i_we | input | 2 | Per-port write select (1 = write) |
| i_srch | input | 2 | Per-port search select for a non-write request |
| i_addr | input | 2×9 | Per-port word or centre address |
| i_wdata | input | 2×32 | Per-port write data |
| o_done | output | 2 | Per-port result present |
| o_inv | output | 2 | Per-port result refers to an unwritten word |
| o_err | output | 2 | Per-port edge centre or row out of range |
| o_data | output | 2×32 | Per-port read word or neighbourhood maximum |
| o_addr | output | 2×9 | Per-port read address or address of the maximum |

## Verification
Every read or search result is due exactly one rising edge after the request cycle. A written word becomes visible to a request made in the following cycle, and a clear takes effect the same way. The bench drives inputs 1 ns after an edge and samples both ports 1 ns after the next edge. Only after sampling does it update its own model with that cycle's clear and writes, port 1 before port 0. The expected value therefore always reflects the memory as it stood before the writes of the request cycle.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
    localparam int NPORT = 2;   // access ports
    localparam int NB    = 3;   // row banks (row index modulo 3)
    localparam int WIN   = 3;   // neighbourhood side
endpackage

// File: rtl/lmx_cmp3.sv
module lmx_cmp3 #(
    parameter int DW = 32
) (
    input  logic [2:0][DW-1:0] v,
    output logic [DW-1:0]      max_v,
    output logic [1:0]         max_i
);
    // strict greater keeps the earliest entry on ties
    always_comb begin
        max_v = v[0];
        max_i = 2'd0;
        if (v[1] > max_v) begin
            max_v = v[1];
            max_i = 2'd1;
        end
        if (v[2] > max_v) begin
            max_v = v[2];
            max_i = 2'd2;
        end
    end
endmodule

// File: rtl/lmx_bank.sv
module lmx_bank
    import lmx_pkg::*;
#(
    parameter int BROWS = 4,
    parameter int COLS  = 32,
    parameter int DW    = 32,
    parameter int CW    = 5,
    parameter int LRW   = 2,
    parameter int LW    = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic [NPORT-1:0]                  wr_en,
    input  logic [NPORT-1:0][LW-1:0]          wr_idx,
    input  logic [NPORT-1:0][DW-1:0]          wr_data,
    input  logic [NPORT-1:0][LRW-1:0]         rd_row,
    input  logic [NPORT-1:0][CW-1:0]          rd_col,
    output logic [NPORT-1:0][WIN-1:0][DW-1:0] rd_word,
    output logic [NPORT-1:0][WIN-1:0]         rd_vld
);
    localparam int NW = BROWS * COLS;

    logic [DW-1:0] mem [NW];
    logic [NW-1:0] vld_d, vld_q;

    always_comb begin
        vld_d = clr ? '0 : vld_q;
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p]) vld_d[wr_idx[p]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    // port 0 is applied last so it wins a same-word collision
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wr_en[p]) mem[wr_idx[p]] <= wr_data[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            for (int j = 0; j < WIN; j++) begin
                int c;
                int idx;
                c = int'(rd_col[p]) + j - 1;
                if (c < 0) c = 0;
                if (c > COLS - 1) c = COLS - 1;
                idx = int'(rd_row[p]) * COLS + c;
                if (idx >= NW) idx = 0;
                rd_word[p][j] = mem[idx];
                rd_vld[p][j]  = vld_q[idx];
            end
        end
    end
endmodule

// File: rtl/lmx_port.sv
module lmx_port
    import lmx_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 32,
    parameter int DW   = 32,
    parameter int CW   = 5,
    parameter int AW   = 9,
    parameter int LRW  = 2,
    parameter int LW   = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic                           we,
    input  logic                           srch,
    input  logic [AW-1:0]                  addr,
    output logic [NB-1:0]                  wr_bank,
    output logic [LW-1:0]                  wr_idx,
    output logic [NB-1:0][LRW-1:0]         req_row,
    output logic [CW-1:0]                  req_col,
    input  logic [NB-1:0][WIN-1:0][DW-1:0] bk_word,
    input  logic [NB-1:0][WIN-1:0]         bk_vld,
    output logic                           o_done,
    output logic                           o_inv,
    output logic                           o_err,
    output logic [DW-1:0]                  o_data,
    output logic [AW-1:0]                  o_addr
);
    typedef struct packed {
        logic          done;
        logic          inv;
        logic          err;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
    } res_t;

    res_t res_d, res_q;

    int row_i, col_i;
    logic oor, edge_c;
    logic [1:0] kb [WIN];
    logic [WIN-1:0][WIN-1:0][DW-1:0] pw;
    logic [WIN-1:0][WIN-1:0]         pv;
    logic [WIN-1:0][DW-1:0] row_max;
    logic [WIN-1:0][1:0]    row_idx;
    logic [DW-1:0] win_val;
    logic [1:0]    win_k;
    logic [AW-1:0] win_addr;

    assign row_i  = int'(addr[AW-1:CW]);
    assign col_i  = int'(addr[CW-1:0]);
    assign oor    = (row_i >= ROWS);
    assign edge_c = (row_i == 0) || (row_i >= ROWS - 1) ||
                    (col_i == 0) || (col_i == COLS - 1);

    // neighbourhood rows to banks
    always_comb begin
        req_row = '0;
        req_col = addr[CW-1:0];
        for (int k = 0; k < WIN; k++) begin
            int rk;
            rk = row_i + k - 1;
            if (rk < 0) rk = 0;
            if (rk > ROWS - 1) rk = ROWS - 1;
            kb[k] = 2'(rk % NB);
            req_row[kb[k]] = LRW'(rk / NB);
        end
    end

    // write decode
    always_comb begin
        wr_bank = '0;
        wr_idx  = LW'((row_i / NB) * COLS + col_i);
        for (int b = 0; b < NB; b++) begin
            wr_bank[b] = en && we && !oor && ((row_i % NB) == b);
        end
    end

    // gather words in raster order
    always_comb begin
        for (int k = 0; k < WIN; k++) begin
            pw[k] = bk_word[kb[k]];
            pv[k] = bk_vld[kb[k]];
        end
    end

    genvar gk;
    generate
        for (gk = 0; gk < WIN; gk++) begin : g_row
            lmx_cmp3 #(.DW(DW)) u_row (
                .v     (pw[gk]),
                .max_v (row_max[gk]),
                .max_i (row_idx[gk])
            );
        end
    endgenerate

    lmx_cmp3 #(.DW(DW)) u_top (
        .v     (row_max),
        .max_v (win_val),
        .max_i (win_k)
    );

    // winning offsets to a word address
    always_comb begin
        int wr_r, wr_c;
        wr_r = row_i + int'(win_k) - 1;
        wr_c = col_i + int'(row_idx[win_k]) - 1;
        win_addr = AW'(wr_r * COLS + wr_c);
    end

    always_comb begin
        res_d      = '0;
        res_d.done = en && !we;
        if (en && !we) begin
            if (srch) begin
                if (edge_c)      res_d.err = 1'b1;
                else if (!(&pv)) res_d.inv = 1'b1;
                else begin
                    res_d.data = win_val;
                    res_d.addr = win_addr;
                end
            end else begin
                if (oor)            res_d.err = 1'b1;
                else if (!pv[1][1]) res_d.inv = 1'b1;
                else begin
                    res_d.data = pw[1][1];
                    res_d.addr = addr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign o_done = res_q.done;
    assign o_inv  = res_q.inv;
    assign o_err  = res_q.err;
    assign o_data = res_q.data;
    assign o_addr = res_q.addr;
endmodule

// File: rtl/lmx_mem.sv
module lmx_mem
    import lmx_pkg::*;
#(
    parameter  int ROWS  = 12,
    parameter  int COLS  = 32,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(COLS),
    localparam int RW    = $clog2(ROWS),
    localparam int AW    = RW + CW,
    localparam int BROWS = (ROWS + NB - 1) / NB,
    localparam int LRW   = (BROWS > 1) ? $clog2(BROWS) : 1,
    localparam int LW    = $clog2(BROWS * COLS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      i_clr,
    input  logic [NPORT-1:0]          i_en,
    input  logic [NPORT-1:0]          i_we,
    input  logic [NPORT-1:0]          i_srch,
    input  logic [NPORT-1:0][AW-1:0]  i_addr,
    input  logic [NPORT-1:0][DW-1:0]  i_wdata,
    output logic [NPORT-1:0]          o_done,
    output logic [NPORT-1:0]          o_inv,
    output logic [NPORT-1:0]          o_err,
    output logic [NPORT-1:0][DW-1:0]  o_data,
    output logic [NPORT-1:0][AW-1:0]  o_addr
);
    logic [NPORT-1:0][NB-1:0]                  p_wr_bank;
    logic [NPORT-1:0][LW-1:0]                  p_wr_idx;
    logic [NPORT-1:0][NB-1:0][LRW-1:0]         p_req_row;
    logic [NPORT-1:0][CW-1:0]                  p_req_col;
    logic [NPORT-1:0][NB-1:0][WIN-1:0][DW-1:0] p_word;
    logic [NPORT-1:0][NB-1:0][WIN-1:0]         p_vld;

    logic [NB-1:0][NPORT-1:0]                  b_wr_en;
    logic [NB-1:0][NPORT-1:0][LRW-1:0]         b_rd_row;
    logic [NB-1:0][NPORT-1:0][WIN-1:0][DW-1:0] b_word;
    logic [NB-1:0][NPORT-1:0][WIN-1:0]         b_vld;

    genvar gp, gb;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port
            lmx_port #(
                .ROWS(ROWS), .COLS(COLS), .DW(DW), .CW(CW),
                .AW(AW), .LRW(LRW), .LW(LW)
            ) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (i_en[gp]),
                .we      (i_we[gp]),
                .srch    (i_srch[gp]),
                .addr    (i_addr[gp]),
                .wr_bank (p_wr_bank[gp]),
                .wr_idx  (p_wr_idx[gp]),
                .req_row (p_req_row[gp]),
                .req_col (p_req_col[gp]),
                .bk_word (p_word[gp]),
                .bk_vld  (p_vld[gp]),
                .o_done  (o_done[gp]),
                .o_inv   (o_inv[gp]),
                .o_err   (o_err[gp]),
                .o_data  (o_data[gp]),
                .o_addr  (o_addr[gp])
            );
            for (gb = 0; gb < NB; gb++) begin : g_x
                assign b_wr_en[gb][gp]  = p_wr_bank[gp][gb];
                assign b_rd_row[gb][gp] = p_req_row[gp][gb];
                assign p_word[gp][gb]   = b_word[gb][gp];
                assign p_vld[gp][gb]    = b_vld[gb][gp];
            end
        end

        for (gb = 0; gb < NB; gb++) begin : g_bank
            lmx_bank #(
                .BROWS(BROWS), .COLS(COLS), .DW(DW),
                .CW(CW), .LRW(LRW), .LW(LW)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (i_clr),
                .wr_en   (b_wr_en[gb]),
                .wr_idx  (p_wr_idx),
                .wr_data (i_wdata),
                .rd_row  (b_rd_row[gb]),
                .rd_col  (p_req_col),
                .rd_word (b_word[gb]),
                .rd_vld  (b_vld[gb])
            );
        end
    endgenerate
endmodule

// File: rtl/lmx_chk.sv
module lmx_chk
    import lmx_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 32,
    parameter int DW   = 32,
    parameter int AW   = 9,
    parameter int CW   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     i_clr,
    input logic [NPORT-1:0]         i_en,
    input logic [NPORT-1:0]         i_we,
    input logic [NPORT-1:0]         i_srch,
    input logic [NPORT-1:0][AW-1:0] i_addr,
    input logic [NPORT-1:0][DW-1:0] i_wdata,
    input logic [NPORT-1:0]         o_done,
    input logic [NPORT-1:0]         o_inv,
    input logic [NPORT-1:0]         o_err,
    input logic [NPORT-1:0][DW-1:0] o_data,
    input logic [NPORT-1:0][AW-1:0] o_addr
);
    function automatic bit on_edge(input logic [AW-1:0] a);
        int r, c;
        r = int'(a[AW-1:CW]);
        c = int'(a[CW-1:0]);
        return (r == 0) || (r >= ROWS - 1) || (c == 0) || (c == COLS - 1);
    endfunction

    function automatic bit near(input logic [AW-1:0] ctr, input logic [AW-1:0] w);
        int dr, dc;
        dr = int'(w[AW-1:CW]) - int'(ctr[AW-1:CW]);
        dc = int'(w[CW-1:0]) - int'(ctr[CW-1:0]);
        return (dr >= -1) && (dr <= 1) && (dc >= -1) && (dc <= 1);
    endfunction

    logic any_wr;
    assign any_wr = |(i_en & i_we);

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_p
            a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
                (i_en[gp] && !i_we[gp]) |=> o_done[gp]);

            a_r2_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
                (!i_en[gp] || i_we[gp]) |=> (!o_done[gp] && !o_inv[gp] && !o_err[gp]));

            a_r8_edge_err: assert property (@(posedge clk) disable iff (!rst_n)
                (i_en[gp] && !i_we[gp] && i_srch[gp] && on_edge(i_addr[gp]))
                |=> (o_err[gp] && !o_inv[gp]));

            a_r4_win_in_window: assert property (@(posedge clk) disable iff (!rst_n)
                (i_en[gp] && !i_we[gp] && i_srch[gp])
                |=> (o_err[gp] || o_inv[gp] || near($past(i_addr[gp]), o_addr[gp])));

            a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (i_clr && !any_wr) ##1 (i_en[gp] && !i_we[gp] && !i_srch[gp])
                |=> (o_inv[gp] || o_err[gp]));
        end
    endgenerate

    a_r1_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (i_en[0] && i_we[0] && (int'(i_addr[0][AW-1:CW]) < ROWS))
        ##1 (i_en[0] && !i_we[0] && !i_srch[0] && (i_addr[0] == $past(i_addr[0])))
        |=> (!o_inv[0] && !o_err[0] && (o_data[0] == $past(i_wdata[0], 2))));
endmodule

bind lmx_mem lmx_chk #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW), .CW(CW)
) u_chk (.*);

// File: tb/sim_lmx_mem.sv
`timescale 1ns/1ps
module sim_lmx_mem;
    localparam int R = 12;
    localparam int C = 32;
    localparam int N = R * C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_clr;
    logic [1:0] i_en, i_we, i_srch;
    logic [1:0][8:0]  i_addr;
    logic [1:0][31:0] i_wdata;
    logic [1:0] o_done, o_inv, o_err;
    logic [1:0][31:0] o_data;
    logic [1:0][8:0]  o_addr;

    int nchk = 0;
    int nerr = 0;
    bit fin = 1'b0;

    logic [31:0] mdl [N];
    bit          mv  [N];

    always #2 clk = ~clk;

    lmx_mem u0 (
        .clk(clk), .rst_n(rst_n), .i_clr(i_clr), .i_en(i_en), .i_we(i_we),
        .i_srch(i_srch), .i_addr(i_addr), .i_wdata(i_wdata), .o_done(o_done),
        .o_inv(o_inv), .o_err(o_err), .o_data(o_data), .o_addr(o_addr)
    );

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'hA5A51234;
    endfunction

    function automatic int adr(input int r, input int c);
        return r * C + c;
    endfunction

    // {done, inv, err, data, addr}
    function automatic logic [43:0] exp_read(input int a);
        if ((a / C) >= R) return {3'b101, 41'd0};
        if (!mv[a])       return {3'b110, 41'd0};
        return {3'b100, mdl[a], 9'(a)};
    endfunction

    function automatic logic [43:0] exp_search(input int a);
        int r, c, best;
        logic [31:0] bv;
        r = a / C;
        c = a % C;
        if (r == 0 || r >= R - 1 || c == 0 || c == C - 1) return {3'b101, 41'd0};
        best = -1;
        bv = '0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int w;
                w = adr(r + dr, c + dc);
                if (!mv[w]) return {3'b110, 41'd0};
                if (best < 0 || mdl[w] > bv) begin
                    best = w;
                    bv = mdl[w];
                end
            end
        end
        return {3'b100, bv, 9'(best)};
    endfunction

    function automatic logic [43:0] exp_port(input int p);
        if (!i_en[p] || i_we[p]) return 44'd0;
        if (i_srch[p]) return exp_search(int'(i_addr[p]));
        return exp_read(int'(i_addr[p]));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] e);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, e);
        end
    endtask

    task automatic idle();
        i_clr = 1'b0; i_en = '0; i_we = '0; i_srch = '0; i_addr = '0; i_wdata = '0;
    endtask

    task automatic setp(input int p, input bit we, input bit sr, input int a, input logic [31:0] d);
        i_en[p] = 1'b1; i_we[p] = we; i_srch[p] = sr; i_addr[p] = 9'(a); i_wdata[p] = d;
    endtask

    task automatic run(input string tag);
        logic [43:0] e0, e1, g;
        e0 = exp_port(0);
        e1 = exp_port(1);
        @(posedge clk); #1;
        g = {o_done[0], o_inv[0], o_err[0], o_data[0], o_addr[0]};
        chk(g == e0, {tag, " port0"}, 64'(g), 64'(e0));
        g = {o_done[1], o_inv[1], o_err[1], o_data[1], o_addr[1]};
        chk(g == e1, {tag, " port1"}, 64'(g), 64'(e1));
        if (i_clr) for (int a = 0; a < N; a++) mv[a] = 1'b0;
        for (int p = 1; p >= 0; p--) begin
            if (i_en[p] && i_we[p] && (int'(i_addr[p]) / C) < R) begin
                mdl[int'(i_addr[p])] = i_wdata[p];
                mv[int'(i_addr[p])] = 1'b1;
            end
        end
        idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int a = 0; a < N; a++) mv[a] = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!fin) begin
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        idle();
        for (int a = 0; a < N; a++) begin mdl[a] = '0; mv[a] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        chk({o_done, o_inv, o_err} == 6'd0, "R2 reset flags", 64'({o_done, o_inv, o_err}), 64'd0);
        chk({o_data, o_addr} == '0, "R2 reset data", 64'(o_data[0]), 64'd0);
        run("R2 idle");
        setp(0, 0, 0, 40, 0);
        setp(1, 0, 1, adr(2, 2), 0);
        run("R3 R9 R7 after reset");

        // R10 fill on both ports together
        for (int i = 0; i < N / 2; i++) begin
            setp(0, 1, 0, 2 * i, pat(2 * i));
            setp(1, 1, 0, 2 * i + 1, pat(2 * i + 1));
            run("R10 R2 fill");
        end

        // R1 read sweep
        for (int i = 0; i < N; i++) begin
            setp(0, 0, 0, i, 0);
            setp(1, 0, 0, N - 1 - i, 0);
            run("R1 read");
        end
        run("R2 done drops");

        // R4 R6 R8 search sweep
        for (int i = 0; i < N; i++) begin
            setp(0, 0, 1, i, 0);
            setp(1, 0, 1, (i * 7) % N, 0);
            run("R4 R6 R8 search");
        end

        // R8 rows beyond the array
        for (int i = N; i < 512; i += 16) begin
            setp(0, 0, 0, i, 0);
            setp(1, 0, 1, i, 0);
            run("R8 out of range");
        end

        // R5 ties in raster order
        for (int r = 4; r <= 6; r++)
            for (int c = 9; c <= 11; c++) begin
                setp(0, 1, 0, adr(r, c), 32'h5);
                run("R5 tie setup");
            end
        setp(0, 0, 1, adr(5, 10), 0);
        run("R5 all equal");
        chk(o_addr[0] == 9'(adr(4, 9)), "R5 all equal winner", 64'(o_addr[0]), 64'(adr(4, 9)));
        setp(0, 1, 0, adr(5, 11), 32'h9);
        setp(1, 1, 0, adr(6, 9), 32'h9);
        run("R5 tie setup");
        setp(0, 0, 1, adr(5, 10), 0);
        run("R5 partial tie");
        chk(o_addr[0] == 9'(adr(5, 11)), "R5 partial tie winner", 64'(o_addr[0]), 64'(adr(5, 11)));

        // R6 unsigned
        setp(0, 1, 0, adr(8, 20), 32'h80000000);
        setp(1, 1, 0, adr(7, 19), 32'h7FFFFFFF);
        run("R6 setup");
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (!((dr == 0 && dc == 0) || (dr == -1 && dc == -1))) begin
                    setp(0, 1, 0, adr(8 + dr, 20 + dc), 32'h1);
                    run("R6 setup");
                end
        setp(1, 0, 1, adr(8, 20), 0);
        run("R6 unsigned");
        chk(o_data[1] == 32'h80000000, "R6 unsigned max", 64'(o_data[1]), 64'h80000000);

        // R10 same-word collision
        setp(0, 1, 0, 100, 32'hAAAA0000);
        setp(1, 1, 0, 100, 32'hBBBB1111);
        run("R10 collision");
        setp(1, 0, 0, 100, 0);
        run("R10 port0 wins");
        chk(o_data[1] == 32'hAAAA0000, "R10 port0 data", 64'(o_data[1]), 64'hAAAA0000);

        // R11 read during write
        setp(0, 1, 0, 101, 32'hC0FFEE01);
        setp(1, 0, 0, 101, 0);
        run("R11 old data");
        setp(1, 0, 0, 101, 0);
        run("R11 new data");

        // R9 clear with a write in the same cycle
        i_clr = 1'b1;
        setp(0, 1, 0, 200, 32'hD00D0200);
        run("R9 clear");
        setp(0, 0, 0, 200, 0);
        setp(1, 0, 0, 201, 0);
        run("R9 survivor and cleared");
        setp(0, 0, 1, 200, 0);
        run("R7 search after clear");

        // R7 one missing word in a neighbourhood
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (!(dr == 1 && dc == 1)) begin
                    setp(1, 1, 0, adr(3 + dr, 3 + dc), pat(dr * 3 + dc + 20));
                    run("R7 setup");
                end
        setp(0, 0, 1, adr(3, 3), 0);
        run("R7 one invalid");
        setp(0, 1, 0, adr(4, 4), 32'hFFFFFFF0);
        setp(1, 0, 1, adr(3, 3), 0);
        run("R7 R11 last write same cycle");
        setp(0, 0, 1, adr(3, 3), 0);
        run("R7 all valid");

        // R9 reset clears valid bits
        do_reset();
        chk({o_done, o_inv, o_err} == 6'd0, "R9 R2 reset flags", 64'({o_done, o_inv, o_err}), 64'd0);
        setp(0, 0, 0, 200, 0);
        setp(1, 0, 0, 100, 0);
        run("R9 read after reset");

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule